// File: doc/BRIEF.md
# Cascadable LCD Column Data Sampler

This block gathers the grayscale words for one row of LCD columns and then presents them all at once. Each clock edge takes three 6-bit words from an 18-bit bus. The words go into a sampling register at one column triplet, and the block moves across the row in a direction chosen by a static select input. A one-cycle start pulse on the enable pin that is acting as input arms the block. Shortly before the row is complete, the block raises a one-cycle pulse on the other enable pin. That pulse can drive the start input of the next device in a chain, so several devices fill a wide panel with no gap between them.

A load strobe copies the full sampling register into a holding register, and every column changes in the same cycle. The holding register is the output of the block. A mode input shortens the row by skipping a fixed group of triplets in the middle. The columns in that group are never written, and they read zero after a load.

Top module: `lcdsamp_top`

## Requirements
- R1: A high level on the input enable pin, sampled at a rising edge while the block is idle, arms the block. The first triplet is latched on the next rising edge, not on the arming edge.
- R2: With `dir_i` high, `ena_a` is the enable input and `ena_b` is the enable output. With `dir_i` low the two roles are swapped. The block never drives the pin that is acting as input.
- R3: Bus bits [6k+5:6k] carry lane k (k = 0..2) as an unsigned word, MSB first, with weights 32/16/8/4/2/1. Lane 0 goes to the lowest column of the triplet, lane 2 to the highest. Column c appears on `hold_o[6c+5:6c]`.
- R4: With `dir_i` high, transfers fill the triplets in ascending order, starting at triplet 0 (columns 0–2).
- R5: With `dir_i` low, transfers fill the triplets in descending order, starting at the highest triplet (columns 306–308 by default).
- R6: A row takes 103 transfers in full mode and 100 in short mode. After the last transfer the block returns to idle, and bus data has no further effect.
- R7: With `mode300_i` high, triplets 50–52 (columns 150–158) are skipped in both directions, and after a load they read zero. Direction and mode are captured when the block arms.
- R8: The enable output is high for exactly one cycle. It rises on the edge that latches the second-to-last transfer and falls on the edge that latches the last one.
- R9: When `load_i` is high at a rising edge, the whole sampling register is copied into `hold_o` on that edge. At any other time `hold_o` keeps its value.
- R10: A start pulse that arrives while a row is in progress is ignored. The row neither restarts nor changes.
- R11: A synchronous `rst` returns the block to idle and drives the enable output low. It does not change the holding register.
- R12: While the block is idle, the enable output pin is driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ena_a | inout | 1 | Enable pin A: input when `dir_i` = 1, output when `dir_i` = 0 |
| ena_b | inout | 1 | Enable pin B: output when `dir_i` = 1, input when `dir_i` = 0 |
| dir_i | input | 1 | Scan direction: 1 = ascending, 0 = descending |
| mode300_i | input | 1 | 1 = short row with the middle triplets skipped |
| load_i | input | 1 | Copy the sampling register into the holding register |
| pix_i | input | 18 | Three 6-bit grayscale words, lane k in bits [6k+5:6k] |
| hold_o | output | 1854 | Holding register, column c in bits [6c+5:6c] |

## Verification
The hardest case to reach from the ports is the short-mode scan in the descending direction. There the transfer count has to step from the triplet above the skipped group to the one below it, and the row must still end on triplet 0 with the cascade pulse one transfer early. The bench uses a small configuration: nine triplets with one skipped in the middle. It fills whole rows in all four direction and mode combinations, using data that encodes the transfer number and the lane, so any misplaced or duplicated triplet shows up as a wrong column value. A stray start pulse in the middle of a row, bus activity after the row ends, and a reset part-way through a row are each followed by a full readback through the load strobe.

// File: rtl/lcdsamp_pkg.sv
package lcdsamp_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } samp_state_t;
endpackage

// File: rtl/lcdsamp_pins.sv
module lcdsamp_pins (
  inout  wire  ena_a,
  inout  wire  ena_b,
  input  logic dir_i,
  input  logic cas_i,
  output logic start_o
);
  // Pin A drives only when scanning descends, pin B only when ascending.
  assign ena_a   = dir_i ? 1'bz : cas_i;
  assign ena_b   = dir_i ? cas_i : 1'bz;
  assign start_o = dir_i ? ena_a : ena_b;
endmodule

// File: rtl/lcdsamp_seq.sv
module lcdsamp_seq
  import lcdsamp_pkg::*;
#(
  parameter int FULL_XFERS = 103,
  parameter int SKIP_FIRST = 50,
  parameter int SKIP_CNT   = 3,
  parameter int SEQ_W      = $clog2(FULL_XFERS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             dir_i,
  input  logic             mode300_i,
  output logic             busy_o,
  output logic             wr_en_o,
  output logic [SEQ_W-1:0] wr_trip_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic             cas_o
);
  localparam logic [SEQ_W-1:0] LAST_FULL  = SEQ_W'(FULL_XFERS - 1);
  localparam logic [SEQ_W-1:0] LAST_SHORT = SEQ_W'(FULL_XFERS - SKIP_CNT - 1);
  localparam logic [SEQ_W-1:0] GAP_LO     = SEQ_W'(SKIP_FIRST);
  localparam logic [SEQ_W-1:0] GAP_HI     = SEQ_W'(SKIP_FIRST + SKIP_CNT);
  localparam logic [SEQ_W-1:0] GAP_N      = SEQ_W'(SKIP_CNT);

  samp_state_t      state_q;
  logic [SEQ_W-1:0] seq_q;
  logic             dir_q;
  logic             short_q;
  logic             cas_q;
  logic [SEQ_W-1:0] last_idx;
  logic [SEQ_W-1:0] asc_trip;
  logic [SEQ_W-1:0] dsc_raw;
  logic [SEQ_W-1:0] dsc_trip;

  always_comb begin
    last_idx = short_q ? LAST_SHORT : LAST_FULL;
    asc_trip = (short_q && seq_q >= GAP_LO) ? seq_q + GAP_N : seq_q;
    dsc_raw  = LAST_FULL - seq_q;
    dsc_trip = (short_q && dsc_raw < GAP_HI) ? dsc_raw - GAP_N : dsc_raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      seq_q   <= '0;
      cas_q   <= 1'b0;
      dir_q   <= 1'b1;
      short_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cas_q <= 1'b0;
          if (start_i) begin
            state_q <= ST_RUN;
            seq_q   <= '0;
            dir_q   <= dir_i;
            short_q <= mode300_i;
          end
        end
        default: begin
          cas_q <= (seq_q == last_idx - SEQ_W'(1));
          if (seq_q == last_idx) begin
            state_q <= ST_IDLE;
            seq_q   <= '0;
          end else begin
            seq_q <= seq_q + SEQ_W'(1);
          end
        end
      endcase
    end
  end

  assign busy_o    = (state_q == ST_RUN);
  assign wr_en_o   = (state_q == ST_RUN);
  assign wr_trip_o = dir_q ? asc_trip : dsc_trip;
  assign seq_o     = seq_q;
  assign cas_o     = cas_q;
endmodule

// File: rtl/lcdsamp_store.sv
module lcdsamp_store #(
  parameter int WORD_W     = 6,
  parameter int LANES      = 3,
  parameter int FULL_XFERS = 103,
  parameter int SKIP_FIRST = 50,
  parameter int SKIP_CNT   = 3,
  parameter int SEQ_W      = $clog2(FULL_XFERS + 1),
  parameter int BUS_W      = LANES * WORD_W,
  parameter int NCOL       = FULL_XFERS * LANES
) (
  input  logic                   clk,
  input  logic                   wr_en_i,
  input  logic [SEQ_W-1:0]       wr_trip_i,
  input  logic [BUS_W-1:0]       pix_i,
  input  logic                   load_i,
  input  logic                   mode300_i,
  output logic [NCOL*WORD_W-1:0] hold_o,
  output logic [WORD_W-1:0]      samp_col0_o
);
  for (genvar t = 0; t < FULL_XFERS; t++) begin : g_trip
    localparam bit IN_GAP = (t >= SKIP_FIRST) && (t < SKIP_FIRST + SKIP_CNT);
    logic hit;
    assign hit = wr_en_i && (wr_trip_i == SEQ_W'(t));
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int COL = t * LANES + k;
      logic [WORD_W-1:0] samp_r;
      logic [WORD_W-1:0] hold_r;
      always_ff @(posedge clk) begin
        if (hit) samp_r <= pix_i[k*WORD_W +: WORD_W];
      end
      always_ff @(posedge clk) begin
        if (load_i) hold_r <= (IN_GAP && mode300_i) ? '0 : samp_r;
      end
      assign hold_o[COL*WORD_W +: WORD_W] = hold_r;
    end
  end

  assign samp_col0_o = g_trip[0].g_lane[0].samp_r;
endmodule

// File: rtl/lcdsamp_top.sv
module lcdsamp_top #(
  parameter int WORD_W     = 6,
  parameter int LANES      = 3,
  parameter int FULL_XFERS = 103,
  parameter int SKIP_FIRST = 50,
  parameter int SKIP_CNT   = 3,
  parameter int BUS_W      = LANES * WORD_W,
  parameter int NCOL       = FULL_XFERS * LANES
) (
  input  logic                   clk,
  input  logic                   rst,
  inout  wire                    ena_a,
  inout  wire                    ena_b,
  input  logic                   dir_i,
  input  logic                   mode300_i,
  input  logic                   load_i,
  input  logic [BUS_W-1:0]       pix_i,
  output logic [NCOL*WORD_W-1:0] hold_o
);
  localparam int SEQ_W = $clog2(FULL_XFERS + 1);

  logic             start;
  logic             busy;
  logic             wr_en;
  logic [SEQ_W-1:0] wr_trip;
  logic [SEQ_W-1:0] seq;
  logic             cas;
  logic [WORD_W-1:0] samp_col0;

  lcdsamp_pins u_pins (
    .ena_a   (ena_a),
    .ena_b   (ena_b),
    .dir_i   (dir_i),
    .cas_i   (cas),
    .start_o (start)
  );

  lcdsamp_seq #(
    .FULL_XFERS (FULL_XFERS),
    .SKIP_FIRST (SKIP_FIRST),
    .SKIP_CNT   (SKIP_CNT),
    .SEQ_W      (SEQ_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start),
    .dir_i     (dir_i),
    .mode300_i (mode300_i),
    .busy_o    (busy),
    .wr_en_o   (wr_en),
    .wr_trip_o (wr_trip),
    .seq_o     (seq),
    .cas_o     (cas)
  );

  lcdsamp_store #(
    .WORD_W     (WORD_W),
    .LANES      (LANES),
    .FULL_XFERS (FULL_XFERS),
    .SKIP_FIRST (SKIP_FIRST),
    .SKIP_CNT   (SKIP_CNT),
    .SEQ_W      (SEQ_W)
  ) u_store (
    .clk         (clk),
    .wr_en_i     (wr_en),
    .wr_trip_i   (wr_trip),
    .pix_i       (pix_i),
    .load_i      (load_i),
    .mode300_i   (mode300_i),
    .hold_o      (hold_o),
    .samp_col0_o (samp_col0)
  );
endmodule

// File: rtl/lcdsamp_chk.sv
module lcdsamp_chk #(
  parameter int WORD_W     = 6,
  parameter int FULL_XFERS = 103,
  parameter int HOLD_W     = 6,
  parameter int SEQ_W      = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              ena_a,
  input logic              ena_b,
  input logic              dir_i,
  input logic              load_i,
  input logic              busy,
  input logic              cas,
  input logic [SEQ_W-1:0]  seq,
  input logic [HOLD_W-1:0] hold_o,
  input logic [WORD_W-1:0] samp_col0
);
  logic armed_q;
  always_ff @(posedge clk) armed_q <= 1'b1;

  // R8
  cas_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    cas |=> !cas);

  // R8
  cas_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cas |-> busy);

  // R6
  seq_bound_chk: assert property (@(posedge clk) disable iff (rst)
    seq < SEQ_W'(FULL_XFERS));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
    !$past(load_i) |-> $stable(hold_o));

  // R9
  load_copy_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
    $past(load_i) |-> hold_o[WORD_W-1:0] == $past(samp_col0));

  // R12
  outpin_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ((dir_i ? ena_b : ena_a) == 1'b0));
endmodule

bind lcdsamp_top lcdsamp_chk #(
  .WORD_W     (WORD_W),
  .FULL_XFERS (FULL_XFERS),
  .HOLD_W     (NCOL * WORD_W),
  .SEQ_W      (SEQ_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ena_a     (ena_a),
  .ena_b     (ena_b),
  .dir_i     (dir_i),
  .load_i    (load_i),
  .busy      (busy),
  .cas       (cas),
  .seq       (seq),
  .hold_o    (hold_o),
  .samp_col0 (samp_col0)
);

// File: tb/lcdsamp_top_tb.sv
module lcdsamp_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 6;
  localparam int LN   = 3;
  localparam int FULL = 9;
  localparam int SF   = 4;
  localparam int SC   = 1;
  localparam int NCOL = FULL * LN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dir = 1'b1;
  logic m300 = 1'b0;
  logic load = 1'b0;
  logic [LN*W-1:0] pix = '0;
  logic [NCOL*W-1:0] hold;
  logic a_en = 1'b1, a_drv = 1'b0, b_en = 1'b0, b_drv = 1'b0;
  wire ena_a, ena_b;

  assign ena_a = a_en ? a_drv : 1'bz;
  assign ena_b = b_en ? b_drv : 1'bz;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit cur_d; bit cur_m; int cur_base;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcdsamp_top #(
    .WORD_W(W), .LANES(LN), .FULL_XFERS(FULL), .SKIP_FIRST(SF), .SKIP_CNT(SC)
  ) u_dut (
    .clk(clk), .rst(rst), .ena_a(ena_a), .ena_b(ena_b), .dir_i(dir),
    .mode300_i(m300), .load_i(load), .pix_i(pix), .hold_o(hold)
  );

  function automatic int lane_val(int s, int k, int base);
    return (base + s * 5 + k * 17) % 64;
  endfunction

  function automatic int exp_word(int c, bit d, bit m, int base);
    int t = c / LN;
    int k = c % LN;
    int sq;
    if (m && t >= SF && t < SF + SC) return 0;
    if (d) sq = (m && t >= SF + SC) ? t - SC : t;
    else   sq = (m && t < SF) ? FULL - 1 - (t + SC) : FULL - 1 - t;
    return lane_val(sq, k, base);
  endfunction

  function automatic logic out_pin();
    return dir ? ena_b : ena_a;
  endfunction

  task automatic check(string req, int act, int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic set_dir(bit d, bit v);
    dir = d;
    a_en = d; b_en = !d;
    a_drv = d ? v : 1'b0;
    b_drv = d ? 1'b0 : v;
  endtask

  task automatic check_hold(string req);
    for (int c = 0; c < NCOL; c++)
      check(req, int'(hold[c*W +: W]), exp_word(c, cur_d, cur_m, cur_base));
  endtask

  // Fill a row; restart_at re-pulses start mid-row, reset_at aborts with rst.
  task automatic do_row(bit d, bit m, int base, bit do_load, int restart_at, int reset_at);
    int nx = m ? FULL - SC : FULL;
    bit cas_ok = 1'b1;
    @(negedge clk);
    m300 = m; set_dir(d, 1'b1); pix = '1;   // garbage during arming cycle (R1)
    @(negedge clk);
    for (int s = 0; s < nx; s++) begin
      if (s > 0 && out_pin() != (s == nx - 1)) cas_ok = 1'b0;
      if (s == reset_at) begin
        rst = 1'b1; set_dir(d, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        check("R11 enable output low after reset", int'(out_pin()), 0);
        return;
      end
      set_dir(d, s == restart_at);
      for (int k = 0; k < LN; k++) pix[k*W +: W] = W'(lane_val(s, k, base));
      @(negedge clk);
    end
    set_dir(d, 1'b0); pix = '0;
    if (out_pin() != 1'b0) cas_ok = 1'b0;
    check("R8 cascade pulse timing", int'(cas_ok), 1);
    if (do_load) begin
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
      cur_d = d; cur_m = m; cur_base = base;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R12 enable output low after reset", int'(out_pin()), 0);
    // R1 R3 R4 R6 R9: ascending full row
    do_row(1'b1, 1'b0, 5, 1'b1, -1, -1);
    check_hold("R4 ascending fill");
    // R5: descending full row
    do_row(1'b0, 1'b0, 11, 1'b1, -1, -1);
    check_hold("R5 descending fill");
    check("R2 enable output on pin A when descending", int'(ena_a), 0);
    // R7: short mode, both directions
    do_row(1'b1, 1'b1, 20, 1'b1, -1, -1);
    check_hold("R7 short ascending");
    do_row(1'b0, 1'b1, 33, 1'b1, -1, -1);
    check_hold("R7 short descending");
    // R9: a filled row without load leaves holding unchanged
    do_row(1'b1, 1'b0, 40, 1'b0, -1, -1);
    check_hold("R9 holding kept without load");
    @(negedge clk); load = 1'b1; @(negedge clk); load = 1'b0;
    cur_d = 1'b1; cur_m = 1'b0; cur_base = 40;
    check_hold("R9 load copies row");
    // R10: stray start mid-row ignored
    do_row(1'b0, 1'b0, 47, 1'b0, 3, -1);
    // R6: bus activity after row end ignored
    for (int i = 0; i < 4; i++) begin pix = '1 - 18'(i); @(negedge clk); end
    pix = '0; load = 1'b1; @(negedge clk); load = 1'b0;
    cur_d = 1'b0; cur_m = 1'b0; cur_base = 47;
    check_hold("R10 R6 row unaffected");
    // R11: reset mid-row keeps holding register
    do_row(1'b1, 1'b0, 52, 1'b0, -1, 4);
    check_hold("R11 holding kept across reset");
    do_row(1'b1, 1'b1, 58, 1'b1, -1, -1);
    check_hold("R11 fresh row after reset");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule